// File: doc/BRIEF.md
# Frame Record and Playback Controller

This block drives an external single-port synchronous word memory so that a stream of frames can be captured and later replayed. Each memory word packs one main data word together with the neighbour word that arrived beside it. The neighbour word sits in the upper half and the main word in the lower half, so a replay reproduces both streams. Frames are a fixed power-of-two number of words. The default is 16 words per frame in a 2^18-word memory, which gives 16k frames.

In record mode the controller is armed first. It then discards input until a word flagged as frame start arrives, and stores that word and every following valid word at consecutive addresses until it is stopped or the memory is full. In playback mode it reads one word per slow phase tick, so the stored frames come back at the cadence of the live input. Each replayed word is emitted with a valid strobe, and the first word of each frame carries a frame-start flag. Playback loops over a programmable number of frames, or runs once and raises an end-of-pattern flag. The current address, split into frame index and word offset, is exported as status for the control bus.

Top module: `frame_replay_ctrl`

## Requirements
- R1: After reset the mode is idle (st_mode 0), st_addr is 0, st_full and st_eop are 0, and neither mem_en nor out_valid is asserted.
- R2: A command with cmd_op 1 (arm) sets st_mode to 1, sets st_addr to 0 and clears both flags. While armed, valid input words without in_sof are not written. The first valid word with in_sof is written to address 0 and moves the mode to 2 (recording).
- R3: While recording, each valid input word is written as {in_nbr, in_data} at st_addr, and st_addr then advances by one. st_frame is the upper ADDR_W-FRAME_W bits of st_addr and st_word is the lower FRAME_W bits.
- R4: A write to the last memory address sets st_full, returns the mode to idle and wraps st_addr to 0. Later input words are not written.
- R5: A command with cmd_op 2 (play) sets st_mode to 3, sets st_addr to 0 and latches cmd_single. While playing, each cycle with phase_tick issues one read at st_addr. In the next cycle out_valid is 1 and the read word appears on out_nbr/out_data. out_sof is 1 exactly when that word's offset within its frame is 0.
- R6: No memory write occurs while the mode is playback.
- R7: Without single-shot, playback returns to address 0 after the last word of frame cfg_frames-1. When cfg_frames is 0 it returns after the last memory word.
- R8: With single-shot, reading the last word of the pattern sets st_eop and returns the mode to idle. No further words are emitted.
- R9: A command with cmd_op 3 (stop) returns the mode to idle, keeps st_addr, and prevents any further memory access.
- R10: A cycle with cmd_valid and a non-zero cmd_op performs no memory access. A cycle with cmd_valid and cmd_op 0 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 2 | 0 none, 1 arm record, 2 play, 3 stop |
| cmd_single | input | 1 | Single-shot selection latched by play |
| cfg_frames | input | ADDR_W-FRAME_W+1 | Frames per playback loop (0 = whole memory) |
| phase_tick | input | 1 | Slow phase marker pacing playback |
| in_valid | input | 1 | Input word valid |
| in_sof | input | 1 | Input word is the first of a frame |
| in_data | input | DATA_W | Main input word |
| in_nbr | input | NBR_W | Neighbour input word |
| mem_en | output | 1 | Memory access enable |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | ADDR_W | Memory address |
| mem_wdata | output | NBR_W+DATA_W | Memory write data |
| mem_rdata | input | NBR_W+DATA_W | Memory read data, one cycle after a read |
| out_valid | output | 1 | Replayed word valid |
| out_sof | output | 1 | Replayed word starts a frame |
| out_data | output | DATA_W | Replayed main word |
| out_nbr | output | NBR_W | Replayed neighbour word |
| st_mode | output | 2 | 0 idle, 1 armed, 2 recording, 3 playing |
| st_addr | output | ADDR_W | Next memory address |
| st_frame | output | ADDR_W-FRAME_W | Frame index of st_addr |
| st_word | output | FRAME_W | Word offset of st_addr |
| st_full | output | 1 | Memory filled in record mode |
| st_eop | output | 1 | Single-shot playback finished |

## Verification
The bench feeds words without a frame-start flag while armed. A design that recorded them would shift every frame and corrupt the first replayed frame-start flag. It fills the memory to its last word, where a design that missed the full condition would keep overwriting from address 0. It replays with random phase ticks over a two-frame loop and over the whole memory (cfg_frames 0). An off-by-one in the wrap or end test shows up there as a wrong word, a misplaced frame-start flag, or a wrong count before end-of-pattern. It also issues stop while a phase tick and an input word are present, where a design that let data win over commands would emit or store one extra word.

// File: rtl/frame_replay_ctrl.sv
module frame_replay_ctrl #(
  parameter int ADDR_W  = 18,
  parameter int FRAME_W = 4,
  parameter int DATA_W  = 16,
  parameter int NBR_W   = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         cmd_valid,
  input  logic [1:0]                   cmd_op,
  input  logic                         cmd_single,
  input  logic [ADDR_W-FRAME_W:0]      cfg_frames,
  input  logic                         phase_tick,
  input  logic                         in_valid,
  input  logic                         in_sof,
  input  logic [DATA_W-1:0]            in_data,
  input  logic [NBR_W-1:0]             in_nbr,
  output logic                         mem_en,
  output logic                         mem_we,
  output logic [ADDR_W-1:0]            mem_addr,
  output logic [NBR_W+DATA_W-1:0]      mem_wdata,
  input  logic [NBR_W+DATA_W-1:0]      mem_rdata,
  output logic                         out_valid,
  output logic                         out_sof,
  output logic [DATA_W-1:0]            out_data,
  output logic [NBR_W-1:0]             out_nbr,
  output logic [1:0]                   st_mode,
  output logic [ADDR_W-1:0]            st_addr,
  output logic [ADDR_W-FRAME_W-1:0]    st_frame,
  output logic [FRAME_W-1:0]           st_word,
  output logic                         st_full,
  output logic                         st_eop
);
  localparam int FRM_W = ADDR_W - FRAME_W + 1;
  localparam int MW    = NBR_W + DATA_W;

  typedef enum logic [1:0] {S_IDLE = 2'd0, S_ARM = 2'd1, S_REC = 2'd2, S_PLAY = 2'd3} mode_t;

  mode_t             mode;
  logic [ADDR_W-1:0] addr;
  logic              single;

  wire cmd_act  = cmd_valid && (cmd_op != 2'd0);
  wire wr       = !cmd_act && in_valid && ((mode == S_ARM && in_sof) || mode == S_REC);
  wire rd       = !cmd_act && phase_tick && (mode == S_PLAY);
  wire last_adr = &addr;
  wire last_wrd = &addr[FRAME_W-1:0];
  wire last_frm = ({1'b0, addr[ADDR_W-1:FRAME_W]} == cfg_frames - {{(FRM_W-1){1'b0}}, 1'b1});
  wire play_end = last_wrd && (last_frm || last_adr);

  assign mem_en    = wr || rd;
  assign mem_we    = wr;
  assign mem_addr  = addr;
  assign mem_wdata = {in_nbr, in_data};
  assign out_data  = mem_rdata[DATA_W-1:0];
  assign out_nbr   = mem_rdata[MW-1:DATA_W];
  assign st_mode   = mode;
  assign st_addr   = addr;
  assign st_frame  = addr[ADDR_W-1:FRAME_W];
  assign st_word   = addr[FRAME_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode      <= S_IDLE;
      addr      <= '0;
      single    <= 1'b0;
      st_full   <= 1'b0;
      st_eop    <= 1'b0;
      out_valid <= 1'b0;
      out_sof   <= 1'b0;
    end else begin
      out_valid <= rd;
      out_sof   <= rd && (addr[FRAME_W-1:0] == '0);
      if (cmd_act) begin
        case (cmd_op)
          2'd1: begin
            mode <= S_ARM; addr <= '0; st_full <= 1'b0; st_eop <= 1'b0;
          end
          2'd2: begin
            mode <= S_PLAY; addr <= '0; single <= cmd_single;
            st_full <= 1'b0; st_eop <= 1'b0;
          end
          default: mode <= S_IDLE;
        endcase
      end else if (wr) begin
        mode <= S_REC;
        addr <= addr + 1'b1;
        if (last_adr) begin
          st_full <= 1'b1;
          mode    <= S_IDLE;
        end
      end else if (rd) begin
        if (play_end) begin
          addr <= '0;
          if (single) begin
            st_eop <= 1'b1;
            mode   <= S_IDLE;
          end
        end else begin
          addr <= addr + 1'b1;
        end
      end
    end
  end

  assert_reset_quiet_R1: assert property (@(posedge clk) !rst_n |=> (st_mode == 2'd0 && !out_valid && !st_full && !st_eop));
  assert_no_write_in_play_R6: assert property (@(posedge clk) disable iff (!rst_n) (st_mode == 2'd3) |-> !mem_we);
  assert_write_advances_R3: assert property (@(posedge clk) disable iff (!rst_n) mem_we |=> (st_addr == ADDR_W'($past(st_addr) + 1'b1)));
  assert_out_after_read_R5: assert property (@(posedge clk) disable iff (!rst_n) out_valid |-> $past(mem_en && !mem_we));
  assert_full_to_idle_R4: assert property (@(posedge clk) disable iff (!rst_n) $rose(st_full) |-> (st_mode == 2'd0 && st_addr == '0));
  assert_eop_to_idle_R8: assert property (@(posedge clk) disable iff (!rst_n) $rose(st_eop) |-> (st_mode == 2'd0));
  assert_cmd_no_access_R10: assert property (@(posedge clk) disable iff (!rst_n) (cmd_valid && cmd_op != 2'd0) |-> !mem_en);
  assert_stop_idle_R9: assert property (@(posedge clk) disable iff (!rst_n) (cmd_valid && cmd_op == 2'd3) |=> (st_mode == 2'd0 && $stable(st_addr)));
endmodule

// File: tb/frame_replay_ctrl_tb_top.sv
module frame_replay_ctrl_tb_top;
  localparam int AW = 8, FB = 4, DW = 16, NW = 16, MW = 32;
  localparam int DEPTH = 1 << AW, FWORDS = 1 << FB;

  logic clk = 0, rst_n = 0;
  logic cmd_valid = 0, cmd_single = 0, phase_tick = 0, in_valid = 0, in_sof = 0;
  logic [1:0] cmd_op = 0;
  logic [AW-FB:0] cfg_frames = 0;
  logic [DW-1:0] in_data = 0;
  logic [NW-1:0] in_nbr = 0;
  logic mem_en, mem_we, out_valid, out_sof, st_full, st_eop;
  logic [AW-1:0] mem_addr, st_addr;
  logic [MW-1:0] mem_wdata, mem_rdata;
  logic [DW-1:0] out_data;
  logic [NW-1:0] out_nbr;
  logic [1:0] st_mode;
  logic [AW-FB-1:0] st_frame;
  logic [FB-1:0] st_word;

  always #2.5 clk = ~clk;

  frame_replay_ctrl #(.ADDR_W(AW), .FRAME_W(FB), .DATA_W(DW), .NBR_W(NW)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_single(cmd_single),
    .cfg_frames(cfg_frames), .phase_tick(phase_tick), .in_valid(in_valid), .in_sof(in_sof),
    .in_data(in_data), .in_nbr(in_nbr), .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .out_valid(out_valid), .out_sof(out_sof),
    .out_data(out_data), .out_nbr(out_nbr), .st_mode(st_mode), .st_addr(st_addr),
    .st_frame(st_frame), .st_word(st_word), .st_full(st_full), .st_eop(st_eop));

  logic [MW-1:0] ram [DEPTH];
  always_ff @(posedge clk) if (mem_en) begin
    if (mem_we) ram[mem_addr] <= mem_wdata;
    else mem_rdata <= ram[mem_addr];
  end

  int nchk = 0, nfail = 0, cyc = 0;
  logic [MW-1:0] exp_mem [DEPTH];
  bit play_on = 0;
  int pidx = 0, plimit = 1, out_cnt = 0;

  function automatic int wrap_next(int i, int lim);
    return (i + 1 == lim) ? 0 : i + 1;
  endfunction

  task automatic chk(bit ok, string req, longint act, longint expv);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  always @(negedge clk) begin
    if (play_on && out_valid) begin
      chk({out_nbr, out_data} == exp_mem[pidx], "R5 data", {out_nbr, out_data}, exp_mem[pidx]);
      chk(out_sof == (pidx % FWORDS == 0), "R5 sof", out_sof, pidx % FWORDS == 0);
      pidx = wrap_next(pidx, plimit);
      out_cnt++;
    end
    if (st_mode == 2'd3 && mem_we) chk(0, "R6 write in play", 1, 0);
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      nfail++; nchk++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  task automatic step(); @(negedge clk); endtask

  task automatic command(logic [1:0] op, logic single);
    cmd_valid = 1; cmd_op = op; cmd_single = single; step();
    cmd_valid = 0; cmd_op = 0; cmd_single = 0;
  endtask

  task automatic rec_word(int k, logic sof);
    in_valid = 1; in_sof = sof; in_data = DW'($urandom); in_nbr = NW'($urandom);
    exp_mem[k] = {in_nbr, in_data};
    step();
    in_valid = 0; in_sof = 0;
  endtask

  task automatic start_play(int frames, logic single, int lim);
    cfg_frames = (AW-FB+1)'(frames);
    pidx = 0; plimit = lim; out_cnt = 0; play_on = 1;
    command(2'd2, single);
  endtask

  initial begin
    int k, cnt_before;
    void'($urandom(32'h5EED_0042));
    repeat (3) step();
    rst_n = 1; step();
    chk(st_mode == 0 && st_addr == 0 && !st_full && !st_eop, "R1 reset state", {st_mode, st_addr}, 0);
    chk(!mem_en && !out_valid, "R1 quiet outputs", {mem_en, out_valid}, 0);

    command(2'd1, 0);
    chk(st_mode == 1 && st_addr == 0, "R2 armed", st_mode, 1);
    for (int i = 0; i < 5; i++) begin
      in_valid = 1; in_sof = 0; in_data = DW'($urandom); #1;
      chk(!mem_we, "R2 pre-sof ignored", mem_we, 0);
      step();
    end
    in_valid = 0;
    chk(st_addr == 0 && st_mode == 1, "R2 still armed", st_addr, 0);

    in_valid = 1; in_sof = 1; in_data = DW'($urandom); in_nbr = NW'($urandom); #1;
    chk(mem_we && mem_addr == 0 && mem_wdata == {in_nbr, in_data}, "R2 first word at 0", mem_addr, 0);
    exp_mem[0] = {in_nbr, in_data};
    step(); in_valid = 0; in_sof = 0;
    chk(st_mode == 2, "R2 recording", st_mode, 2);
    k = 1;
    while (k < 40) begin
      if ($urandom % 4 == 0) step();
      else begin rec_word(k, logic'($urandom % 2)); k++; end
    end
    chk(st_addr == 40 && st_frame == 2 && st_word == 8, "R3 address status", st_addr, 40);

    cmd_valid = 1; cmd_op = 0; rec_word(40, 0); cmd_valid = 0;
    chk(st_addr == 41 && st_mode == 2, "R10 op 0 no effect", st_addr, 41);
    cmd_valid = 1; cmd_op = 3; in_valid = 1; #1;
    chk(!mem_en, "R10 command wins over data", mem_en, 0);
    step(); cmd_valid = 0; cmd_op = 0; in_valid = 0;
    chk(st_mode == 0 && st_addr == 41, "R9 stop keeps address", st_addr, 41);

    start_play(2, 0, 2 * FWORDS);
    chk(st_mode == 3 && st_addr == 0, "R5 play entry", st_mode, 3);
    for (int i = 0; i < 240; i++) begin
      phase_tick = ($urandom % 3 == 0); step();
    end
    chk(out_cnt > 2 * FWORDS, "R7 loop passed wrap", out_cnt, 2 * FWORDS + 1);
    phase_tick = 1; cmd_valid = 1; cmd_op = 3; step();
    cmd_valid = 0; cmd_op = 0; step();
    cnt_before = out_cnt;
    repeat (5) step();
    phase_tick = 0;
    chk(out_cnt == cnt_before && st_mode == 0, "R9 stop halts playback", out_cnt, cnt_before);

    start_play(1, 1, FWORDS);
    phase_tick = 1;
    repeat (FWORDS + 6) step();
    phase_tick = 0;
    chk(out_cnt == FWORDS, "R8 single-shot length", out_cnt, FWORDS);
    chk(st_eop && st_mode == 0, "R8 end of pattern", {st_eop, st_mode}, 4);

    command(2'd1, 0);
    chk(!st_eop, "R2 arm clears flags", st_eop, 0);
    rec_word(0, 1);
    for (int i = 1; i < DEPTH; i++) rec_word(i, logic'($urandom % 2));
    chk(st_full && st_mode == 0 && st_addr == 0, "R4 full", {st_full, st_mode}, 4);
    for (int i = 0; i < 3; i++) begin
      in_valid = 1; in_sof = logic'(i == 0); #1;
      chk(!mem_en, "R4 input ignored when full", mem_en, 0);
      step();
    end
    in_valid = 0; in_sof = 0;

    start_play(0, 1, DEPTH);
    chk(!st_full, "R5 play clears full", st_full, 0);
    phase_tick = 1;
    repeat (DEPTH + 6) step();
    phase_tick = 0;
    chk(out_cnt == DEPTH, "R7 whole memory with cfg 0", out_cnt, DEPTH);
    chk(st_eop && st_mode == 0, "R8 eop after whole memory", st_eop, 1);
    play_on = 0;

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule